// File: doc/BRIEF.md
# Discrete HMM Viterbi Scorer

This block rates a sequence of vector-quantizer codebook indices against one discrete hidden Markov model of ten states over a 128-symbol alphabet. It finds the probability of the single most likely state path, names the state that path ends in, and recovers the whole state path by walking stored back-pointers. A host first writes the initial-state weights, the state-to-state transition weights and the per-state emission weights through a write port, and writes the observation indices into a small sequence buffer. It then pulses start with a sequence length. To pick the best of several word models, the host runs the block once per model and compares the returned scores.

All probabilities are kept in a compact floating format: a 16-bit unsigned mantissa and a signed 10-bit exponent. Every product goes through a normalizer that shifts out leading zeros and corrects the exponent, so scores over long sequences do not underflow to zero. Emission weights written as zero are replaced on entry by a small floor value, so a symbol never seen in training cannot zero a path.

The recursion is sequential. For each time step and target state, one candidate per source state is formed in one cycle, and a running maximum is kept. When the run completes, done pulses for one cycle. The score, the final state and the path stay readable until the next start.

Top module: `hvit_scorer`

## Requirements
- R1: A value is mantissa/2^15 × 2^exponent, with the exponent in two's complement. A mantissa of 0 means zero. Every nonzero result the block produces has mantissa bit 15 set.
- R2: A product takes the full 32-bit mantissa product and shifts it left until bit 31 is set. It keeps bits 31..16, discarding the rest. Its exponent is ea+eb+1−shift, saturated to the range −512..511. If either operand is zero, the result is zero with exponent 0.
- R3: For the first observation O0, each state i gets the score pi_i × b_i(O0).
- R4: For steps t ≥ 1, state j gets the score (max over i of delta_{t−1}(i) × a_ij) × b_j(O_t), multiplied in that order. The maximizing i is stored as the back-pointer of (t, j).
- R5: At the end, the score outputs carry the largest delta of the last step, and final_state carries its state index.
- R6: When a maximum is taken over equal scores (or over all-zero candidates), the lowest state index wins.
- R7: An emission entry written with mantissa 0 is stored as the floor value: mantissa 0x8000, exponent −512.
- R8: path_state at position p gives the state at step p. Position T−1 holds final_state, and position t holds the back-pointer of (t+1, state at t+1).
- R9: A start pulse while idle latches seq_len (1..64). busy rises on the next cycle. When backtracking completes, done is high for exactly one cycle, and busy falls on the same edge. The results are held until the next start.
- R10: A start pulse that arrives while busy is ignored. The run in progress completes with its original length and results.
- R11: Write port encoding: wr_sel 0 writes pi at wr_addr = i; wr_sel 1 writes a_ij at wr_addr = i×10+j; wr_sel 2 writes b_j(k) at wr_addr = j×128+k. Observation k at step p is written with obs_wr, obs_pos = p, obs_sym = k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Model-parameter write strobe |
| wr_sel | input | 2 | Parameter table select (0 initial, 1 transition, 2 emission) |
| wr_addr | input | 11 | Entry address within the selected table |
| wr_mant | input | 16 | Mantissa of the value written (normalized or zero) |
| wr_exp | input | 10 | Signed exponent of the value written |
| obs_wr | input | 1 | Observation buffer write strobe |
| obs_pos | input | 6 | Step index of the observation written |
| obs_sym | input | 7 | Codebook index of the observation |
| start | input | 1 | Run request pulse |
| seq_len | input | 7 | Number of observations, 1..64 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| score_mant | output | 16 | Best path score mantissa |
| score_exp | output | 10 | Best path score signed exponent |
| final_state | output | 4 | State index at the last step |
| path_pos | input | 6 | Step index for path readout |
| path_state | output | 4 | State at step path_pos |

## Verification
Two functions can meet in a single multiply: the emission floor substitution and exponent saturation. When a floor entry at exponent −512 scales any path score, the result drops straight to the saturation limit. The bench provokes this by writing an all-zero emission column and scoring a one-step sequence on it. It expects a nonzero score pinned at exponent −512 that still matches its reference model. A second collision is a new start request during the recursion. The bench injects one mid-run with a different length and judges it by the unchanged final score, path, and single done pulse.

// File: rtl/hvit_pkg.sv
package hvit_pkg;
  localparam int MW   = 16;
  localparam int EW   = 10;
  localparam int EMAX = (1 << (EW - 1)) - 1;
  localparam int EMIN = -(1 << (EW - 1));

  typedef struct packed {
    logic [MW-1:0]        mant;
    logic signed [EW-1:0] expo;
  } hfp_t;

  localparam hfp_t HFP_ZERO  = '{mant: '0, expo: '0};
  localparam hfp_t HFP_FLOOR = '{mant: {1'b1, {(MW-1){1'b0}}}, expo: EW'(EMIN)};

  // Normalizing product: strip leading zeros, keep top MW bits, saturate exponent.
  function automatic hfp_t hfp_mul(hfp_t x, hfp_t y);
    logic [2*MW-1:0] prod;
    int lead;
    int sh;
    int e;
    hfp_t r;
    prod = {{MW{1'b0}}, x.mant} * {{MW{1'b0}}, y.mant};
    lead = 0;
    for (int k = 0; k < 2*MW; k++) if (prod[k]) lead = k;
    if (prod == '0) begin
      r = HFP_ZERO;
    end else begin
      sh   = 2*MW - 1 - lead;
      prod = prod << sh;
      e    = int'(x.expo) + int'(y.expo) + 1 - sh;
      if (e > EMAX) e = EMAX;
      if (e < EMIN) e = EMIN;
      r.mant = prod[2*MW-1 -: MW];
      r.expo = EW'(e);
    end
    return r;
  endfunction

  // Strict greater-than on nonnegative values; zero is the smallest.
  function automatic logic hfp_gt(hfp_t x, hfp_t y);
    if (x.mant == '0) return 1'b0;
    if (y.mant == '0) return 1'b1;
    if (x.expo != y.expo) return x.expo > y.expo;
    return x.mant > y.mant;
  endfunction
endpackage

// File: rtl/hvit_fmul.sv
module hvit_fmul
  import hvit_pkg::*;
(
  input  hfp_t a,
  input  hfp_t b,
  output hfp_t y
);
  assign y = hfp_mul(a, b);
endmodule

// File: rtl/hvit_param_store.sv
module hvit_param_store
  import hvit_pkg::*;
#(
  parameter int N  = 10,
  parameter int M  = 128,
  parameter int T  = 64,
  parameter int SW = $clog2(N),
  parameter int YW = $clog2(M),
  parameter int TW = $clog2(T),
  parameter int AW = $clog2(N*M)
)(
  input  logic          clk,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  hfp_t          wr_val,
  input  logic          obs_wr,
  input  logic [TW-1:0] obs_pos,
  input  logic [YW-1:0] obs_sym,
  input  logic [SW-1:0] rd_i,
  input  logic [SW-1:0] rd_j,
  input  logic [TW-1:0] rd_t,
  output hfp_t          pi_q,
  output hfp_t          a_q,
  output hfp_t          b_q
);
  localparam logic [AW-1:0] PI_CNT = AW'(N);
  localparam logic [AW-1:0] A_CNT  = AW'(N*N);
  localparam logic [AW-1:0] B_CNT  = AW'(N*M);
  localparam logic [AW-1:0] A_ROW  = AW'(N);
  localparam logic [AW-1:0] B_ROW  = AW'(M);

  hfp_t          pi_mem  [N];
  hfp_t          a_mem   [N][N];
  hfp_t          b_mem   [N][M];
  logic [YW-1:0] obs_mem [T];
  logic [YW-1:0] seen_sym;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_sel)
        2'd0: if (wr_addr < PI_CNT) pi_mem[wr_addr] <= wr_val;
        2'd1: if (wr_addr < A_CNT) a_mem[wr_addr / A_ROW][wr_addr % A_ROW] <= wr_val;
        2'd2: if (wr_addr < B_CNT)
                b_mem[wr_addr / B_ROW][wr_addr % B_ROW] <= (wr_val.mant == '0) ? HFP_FLOOR : wr_val;
        default: ;
      endcase
    end
    if (obs_wr) obs_mem[obs_pos] <= obs_sym;
  end

  assign seen_sym = obs_mem[rd_t];
  assign pi_q     = pi_mem[rd_j];
  assign a_q      = a_mem[rd_i][rd_j];
  assign b_q      = b_mem[rd_j][seen_sym];
endmodule

// File: rtl/hvit_bptr_store.sv
module hvit_bptr_store #(
  parameter int N  = 10,
  parameter int T  = 64,
  parameter int SW = $clog2(N),
  parameter int TW = $clog2(T)
)(
  input  logic          clk,
  input  logic          bp_we,
  input  logic [TW-1:0] bp_t,
  input  logic [SW-1:0] bp_j,
  input  logic [SW-1:0] bp_d,
  input  logic [TW-1:0] bp_rt,
  input  logic [SW-1:0] bp_rj,
  output logic [SW-1:0] bp_q,
  input  logic          pth_we,
  input  logic [TW-1:0] pth_wpos,
  input  logic [SW-1:0] pth_d,
  input  logic [TW-1:0] pth_rpos,
  output logic [SW-1:0] pth_q
);
  logic [SW-1:0] bp_mem  [T][N];
  logic [SW-1:0] pth_mem [T];

  always_ff @(posedge clk) begin
    if (bp_we)  bp_mem[bp_t][bp_j] <= bp_d;
    if (pth_we) pth_mem[pth_wpos]  <= pth_d;
  end

  assign bp_q  = bp_mem[bp_rt][bp_rj];
  assign pth_q = pth_mem[pth_rpos];
endmodule

// File: rtl/hvit_scorer.sv
module hvit_scorer
  import hvit_pkg::*;
#(
  parameter int N_STATES = 10,
  parameter int N_SYMS   = 128,
  parameter int MAX_T    = 64,
  parameter int SW = $clog2(N_STATES),
  parameter int YW = $clog2(N_SYMS),
  parameter int TW = $clog2(MAX_T),
  parameter int AW = $clog2(N_STATES*N_SYMS)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic [MW-1:0] wr_mant,
  input  logic [EW-1:0] wr_exp,
  input  logic          obs_wr,
  input  logic [TW-1:0] obs_pos,
  input  logic [YW-1:0] obs_sym,
  input  logic          start,
  input  logic [TW:0]   seq_len,
  output logic          busy,
  output logic          done,
  output logic [MW-1:0] score_mant,
  output logic [EW-1:0] score_exp,
  output logic [SW-1:0] final_state,
  input  logic [TW-1:0] path_pos,
  output logic [SW-1:0] path_state
);
  localparam int LW = TW + 1;
  localparam logic [SW-1:0] LAST_S = SW'(N_STATES - 1);
  localparam logic [LW-1:0] ONE_L  = LW'(1);
  localparam logic [LW-1:0] MAX_L  = LW'(MAX_T);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_REC, S_ROLL, S_FIN, S_BACK} st_e;

  st_e           st_q;
  logic [TW-1:0] t_q;
  logic [SW-1:0] j_q, i_q, arg_q, cur_q;
  logic [LW-1:0] len_q;
  hfp_t          best_q;
  hfp_t          dprev [N_STATES];
  hfp_t          dcur  [N_STATES];

  // Named internal events (observed by the checker)
  hfp_t          wr_val, pi_q, a_q, b_q, prod_y, emit_in, emit_y, cand, win;
  logic          take, last_i, last_j, use_emit, len_one, t_last;
  logic [SW-1:0] win_arg, bp_q;
  logic          bp_we, pth_we;
  logic [TW-1:0] pth_wpos;
  logic [SW-1:0] pth_d;
  logic [LW-1:0] len_in;

  assign wr_val = {wr_mant, wr_exp};

  hvit_param_store #(.N(N_STATES), .M(N_SYMS), .T(MAX_T)) u_params (
    .clk(clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_val(wr_val),
    .obs_wr(obs_wr), .obs_pos(obs_pos), .obs_sym(obs_sym),
    .rd_i(i_q), .rd_j(j_q), .rd_t(t_q),
    .pi_q(pi_q), .a_q(a_q), .b_q(b_q)
  );

  hvit_fmul u_mul_trans (.a(dprev[i_q]), .b(a_q), .y(prod_y));
  hvit_fmul u_mul_emit  (.a(emit_in),    .b(b_q), .y(emit_y));

  assign last_i   = (i_q == LAST_S);
  assign last_j   = (j_q == LAST_S);
  assign len_one  = (len_q == ONE_L);
  assign t_last   = ({1'b0, t_q} == len_q - ONE_L);
  assign use_emit = (st_q == S_INIT) || (st_q == S_REC);
  assign cand     = (st_q == S_FIN) ? dprev[i_q] : prod_y;
  assign take     = (i_q == '0) || hfp_gt(cand, best_q);
  assign win      = take ? cand : best_q;
  assign win_arg  = take ? i_q : arg_q;
  assign emit_in  = (st_q == S_INIT) ? pi_q : win;

  assign bp_we    = (st_q == S_REC) && last_i;
  assign pth_we   = ((st_q == S_FIN) && last_i) || (st_q == S_BACK);
  assign pth_wpos = (st_q == S_BACK) ? t_q - TW'(1) : TW'(len_q - ONE_L);
  assign pth_d    = (st_q == S_BACK) ? bp_q : win_arg;

  hvit_bptr_store #(.N(N_STATES), .T(MAX_T)) u_bptr (
    .clk(clk), .bp_we(bp_we), .bp_t(t_q), .bp_j(j_q), .bp_d(win_arg),
    .bp_rt(t_q), .bp_rj(cur_q), .bp_q(bp_q),
    .pth_we(pth_we), .pth_wpos(pth_wpos), .pth_d(pth_d),
    .pth_rpos(path_pos), .pth_q(path_state)
  );

  assign len_in = (seq_len == '0) ? ONE_L : ((seq_len > MAX_L) ? MAX_L : seq_len);

  // Score arrays: no reset needed, every entry is written before it is read
  always_ff @(posedge clk) begin
    if (st_q == S_INIT) dprev[j_q] <= emit_y;
    if (st_q == S_REC && last_i) dcur[j_q] <= emit_y;
    if (st_q == S_ROLL)
      for (int k = 0; k < N_STATES; k++) dprev[k] <= dcur[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; busy <= 1'b0; done <= 1'b0;
      t_q <= '0; j_q <= '0; i_q <= '0; arg_q <= '0; cur_q <= '0;
      len_q <= ONE_L; best_q <= HFP_ZERO;
      score_mant <= '0; score_exp <= '0; final_state <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          len_q <= len_in; t_q <= '0; j_q <= '0; i_q <= '0;
          busy <= 1'b1; st_q <= S_INIT;
        end
        S_INIT: begin
          j_q <= j_q + SW'(1);
          if (last_j) begin
            j_q <= '0;
            if (len_one) st_q <= S_FIN;
            else begin t_q <= TW'(1); st_q <= S_REC; end
          end
        end
        S_REC: begin
          best_q <= win; arg_q <= win_arg; i_q <= i_q + SW'(1);
          if (last_i) begin
            i_q <= '0; j_q <= j_q + SW'(1);
            if (last_j) begin j_q <= '0; st_q <= S_ROLL; end
          end
        end
        S_ROLL: begin
          if (t_last) st_q <= S_FIN;
          else begin t_q <= t_q + TW'(1); st_q <= S_REC; end
        end
        S_FIN: begin
          best_q <= win; arg_q <= win_arg; i_q <= i_q + SW'(1);
          if (last_i) begin
            i_q <= '0;
            score_mant <= win.mant; score_exp <= win.expo;
            final_state <= win_arg; cur_q <= win_arg;
            t_q <= TW'(len_q - ONE_L);
            if (len_one) begin done <= 1'b1; busy <= 1'b0; st_q <= S_IDLE; end
            else st_q <= S_BACK;
          end
        end
        S_BACK: begin
          cur_q <= bp_q; t_q <= t_q - TW'(1);
          if (t_q == TW'(1)) begin done <= 1'b1; busy <= 1'b0; st_q <= S_IDLE; end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hvit_scorer_chk.sv
module hvit_scorer_chk
  import hvit_pkg::*;
#(
  parameter int N_STATES = 10,
  parameter int SW = 4,
  parameter int LW = 7
)(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [SW-1:0] final_state,
  input logic [LW-1:0] len_q,
  input hfp_t          prod_y,
  input hfp_t          emit_y,
  input hfp_t          b_q,
  input logic          use_emit,
  input logic          bp_we,
  input logic [SW-1:0] win_arg
);
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9: busy is released on the edge that raises done
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R10: a start request during a run leaves the latched length alone
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(len_q));
  // R1 / R2: multiplier results are normalized or zero
  a_r2_norm_trans: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (prod_y.mant[15] || prod_y.mant == '0));
  a_r2_norm_emit: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (emit_y.mant[15] || emit_y.mant == '0));
  // R7: emission operands seen by the recursion are never zero
  a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
    use_emit |-> (b_q.mant != '0));
  // R4: stored back-pointers name a real state
  a_r4_bptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    bp_we |-> (win_arg < SW'(N_STATES)));
  // R5: reported final state is a real state
  a_r5_state_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (final_state < SW'(N_STATES)));
endmodule

bind hvit_scorer hvit_scorer_chk #(.N_STATES(N_STATES), .SW(SW), .LW(TW+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .final_state(final_state), .len_q(len_q), .prod_y(prod_y), .emit_y(emit_y),
  .b_q(b_q), .use_emit(use_emit), .bp_we(bp_we), .win_arg(win_arg)
);

// File: tb/test_hvit_scorer.sv
`timescale 1ns/1ps
module test_hvit_scorer;
  localparam int NS = 10;
  localparam int NY = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, obs_wr = 0, start = 0;
  logic [1:0] wr_sel = 0;
  logic [10:0] wr_addr = 0;
  logic [15:0] wr_mant = 0;
  logic [9:0] wr_exp = 0;
  logic [5:0] obs_pos = 0, path_pos = 0;
  logic [6:0] obs_sym = 0, seq_len = 0;
  logic busy, done;
  logic [15:0] score_mant;
  logic [9:0] score_exp;
  logic [3:0] final_state, path_state;

  int checks = 0, errors = 0;
  int pim[NS], pie[NS], am[NS][NS], ae[NS][NS], bm[NS][NY], be[NS][NY], ob[64];
  int r_m, r_e, r_st, r_path[64];

  always #4 clk = ~clk;

  hvit_scorer i_hvit_scorer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_mant(wr_mant), .wr_exp(wr_exp), .obs_wr(obs_wr), .obs_pos(obs_pos),
    .obs_sym(obs_sym), .start(start), .seq_len(seq_len), .busy(busy), .done(done),
    .score_mant(score_mant), .score_exp(score_exp), .final_state(final_state),
    .path_pos(path_pos), .path_state(path_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // R2 restated: top bit set -> keep p>>16, exponent+1; else keep p>>15.
  function automatic void bmul(input int ma, input int ea, input int mb, input int eb,
                               output int mr, output int er);
    longint p;
    p = longint'(ma) * longint'(mb);
    if (p == 0) begin mr = 0; er = 0; return; end
    if (p >= 64'h8000_0000) begin mr = int'(p >> 16); er = ea + eb + 1; end
    else begin mr = int'(p >> 15); er = ea + eb; end
    if (er > 511) er = 511;
    if (er < -512) er = -512;
  endfunction

  function automatic bit bgt(input int xm, input int xe, input int ym, input int ye);
    if (xm == 0) return 0;
    if (ym == 0) return 1;
    if (xe != ye) return xe > ye;
    return xm > ym;
  endfunction

  task automatic put(input int sel, input int addr, input int m, input int e);
    @(negedge clk);
    wr_en = 1; wr_sel = sel[1:0]; wr_addr = addr[10:0]; wr_mant = m[15:0]; wr_exp = e[9:0];
  endtask

  function automatic int rmant(input bit zeros);
    if (zeros && ($urandom % 8) == 0) return 0;
    return 32'h8000 | ($urandom & 32'h7fff);
  endfunction

  // kind 0: random; 1: all equal (ties); 2: very small emissions
  task automatic load_model(input int kind);
    for (int i = 0; i < NS; i++) begin
      pim[i] = (kind == 1) ? 32'h8000 : rmant(1);
      pie[i] = (kind == 1) ? 0 : -int'($urandom % 4);
      put(0, i, pim[i], pie[i]);
    end
    for (int i = 0; i < NS; i++)
      for (int j = 0; j < NS; j++) begin
        am[i][j] = (kind == 1) ? 32'hC000 : rmant(1);
        ae[i][j] = (kind == 1) ? -1 : -int'($urandom % 4);
        put(1, i*NS + j, am[i][j], ae[i][j]);
      end
    for (int j = 0; j < NS; j++)
      for (int k = 0; k < NY; k++) begin
        bm[j][k] = (kind == 1) ? 32'hA000 : rmant(kind == 0);
        be[j][k] = (kind == 1) ? -2 : ((kind == 2) ? -20 - int'($urandom % 10) : -int'($urandom % 8));
        put(2, j*NY + k, bm[j][k], be[j][k]);
        if (bm[j][k] == 0) begin bm[j][k] = 32'h8000; be[j][k] = -512; end  // R7
      end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic load_obs(input int len, input int fixed);
    for (int p = 0; p < len; p++) begin
      ob[p] = (fixed >= 0) ? fixed : int'($urandom % NY);
      @(negedge clk); obs_wr = 1; obs_pos = p[5:0]; obs_sym = ob[p][6:0];
    end
    @(negedge clk) obs_wr = 0;
  endtask

  task automatic ref_run(input int len);
    int dm[NS], de[NS], nm[NS], ne[NS], psi[64][NS];
    int cm, ce, wm, we, wa;
    for (int i = 0; i < NS; i++) bmul(pim[i], pie[i], bm[i][ob[0]], be[i][ob[0]], dm[i], de[i]);
    for (int t = 1; t < len; t++) begin
      for (int j = 0; j < NS; j++) begin
        wm = 0; we = 0; wa = 0;
        for (int i = 0; i < NS; i++) begin
          bmul(dm[i], de[i], am[i][j], ae[i][j], cm, ce);
          if (i == 0 || bgt(cm, ce, wm, we)) begin wm = cm; we = ce; wa = i; end
        end
        bmul(wm, we, bm[j][ob[t]], be[j][ob[t]], nm[j], ne[j]);
        psi[t][j] = wa;
      end
      dm = nm; de = ne;
    end
    r_m = dm[0]; r_e = de[0]; r_st = 0;
    for (int i = 1; i < NS; i++)
      if (bgt(dm[i], de[i], r_m, r_e)) begin r_m = dm[i]; r_e = de[i]; r_st = i; end
    r_path[len-1] = r_st;
    for (int t = len - 1; t >= 1; t--) r_path[t-1] = psi[t][r_path[t]];
  endtask

  task automatic run_check(input int len, input int poke, input string tag);
    int ndone, cyc;
    ref_run(len);
    @(negedge clk); start = 1; seq_len = len[6:0];
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R9 busy after start", int'(busy), 1);
    ndone = 0; cyc = 0;
    while (ndone == 0 && cyc < 20000) begin
      if (poke != 0 && cyc == 30) begin start = 1; seq_len = 7'd3; end
      else start = 0;
      @(negedge clk); cyc++;
      if (done) ndone++;
    end
    start = 0;
    chk(ndone == 1, {"R9 done seen ", tag}, ndone, 1);
    chk(busy === 1'b0, "R9 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", int'(done), 0);
    chk(int'(score_mant) == r_m, {"R4 R11 score mantissa ", tag}, int'(score_mant), r_m);
    chk(int'($signed(score_exp)) == r_e, {"R4 score exponent ", tag}, int'($signed(score_exp)), r_e);
    chk(score_mant[15] || score_mant == 0, "R1 score normalized", int'(score_mant), 32'h8000);
    chk(int'(final_state) == r_st, {"R5 final state ", tag}, int'(final_state), r_st);
    for (int p = 0; p < len; p++) begin
      path_pos = p[5:0]; #1;
      chk(int'(path_state) == r_path[p], {"R8 path ", tag}, int'(path_state), r_path[p]);
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R9 reset idle", int'({busy, done}), 0);
    chk(score_mant == 0 && final_state == 0, "R5 reset results", int'(score_mant), 0);

    load_model(0);
    load_obs(64, -1);
    run_check(64, 0, "random T64");
    run_check(17, 0, "random T17");
    run_check(1, 0, "R3 init only T1");
    run_check(40, 1, "R10 start while busy");

    load_model(1);
    load_obs(20, -1);
    run_check(20, 0, "R6 ties");
    chk(final_state == 0, "R6 tie lowest state", int'(final_state), 0);

    load_model(0);
    for (int j = 0; j < NS; j++) put(2, j*NY + 5, 0, 0);
    @(negedge clk) wr_en = 0;
    for (int j = 0; j < NS; j++) begin bm[j][5] = 32'h8000; be[j][5] = -512; end
    load_obs(1, 5);
    run_check(1, 0, "R7 floor emission");
    chk(score_mant != 0, "R7 score nonzero", int'(score_mant), 32'h8000);
    chk(int'($signed(score_exp)) == -512, "R2 saturated exponent", int'($signed(score_exp)), -512);

    load_model(2);
    load_obs(64, -1);
    run_check(64, 0, "R2 deep underflow");

    for (int s = 0; s < 2; s++) begin
      load_model(0);
      load_obs(64, -1);
      run_check(2 + int'($urandom % 63), 0, "random length");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule